// File: doc/BRIEF.md
# Operand Address Sequencer

This unit takes one 6-bit operand specifier for a 16-bit machine with eight general registers and works out where the operand lives. The answer is either a register number (the operand is the register itself) or a final memory address. On the way it may read a register, write an incremented or decremented value back into it, fetch an extension word from the instruction stream, and follow a pointer through memory. Register 7 is the program counter. Immediate, absolute and PC-relative operands therefore come out of the ordinary mode rules and need no special casing.

A pulse on `start_i` captures the specifier and the byte/word flag. The unit then steps through its own sequence while `busy_o` is high. It ends with a one-cycle `done_o`, or with a one-cycle `odd_trap_o` if a word access would land on an odd address. Register reads go through a combinational read port. Register updates leave on a one-cycle write strobe and are expected to be committed by the register file at the next clock edge. Memory reads use a request held high until the cycle in which valid is returned with the data.

Top module: `oea_seq`

## Requirements
- R1: The specifier is split into a mode in bits 5:3 and a register number in bits 2:0. Mode 0 completes with `is_reg_o`=1 and `reg_sel_o` equal to the register number. It issues no memory read and no register write.
- R2: Mode 1 completes with `addr_o` equal to the register contents and leaves the register unchanged.
- R3: Mode 2 returns the old register value as the address and writes back the register plus the step. Mode 4 writes back the register minus the step and returns that new value as the address. In both modes the write strobe is active for exactly one cycle, the cycle after `start_i` is taken.
- R4: The step is 1 only for a byte operation in mode 2 or 4 on registers 0 to 5. In every other case it is 2: word operations, registers 6 and 7, and modes 3 and 5.
- R5: Modes 3 and 5 form the same address as modes 2 and 4 and perform the same write-back. They then read one word at that address, and the returned word is the final address.
- R6: Modes 6 and 7 read an extension word at the address held in register 7 and write register 7 plus 2 back to it. The address is the extension word plus the named register as read after that update, so register 7 as a base gives the PC that follows the extension word. Mode 7 then reads one more word at the sum, and that word is the final address.
- R7: A pointer or extension read aimed at an odd address raises a one-cycle `odd_trap_o` instead of `done_o`. So does an odd final address in a word operation. In either case `addr_o` holds the offending address and no memory request goes out to it. If the trap is found in the first cycle after start, the register write-back is suppressed. An odd final address in a byte operation is legal.
- R8: `busy_o` is high from the cycle after `start_i` is taken until the completion cycle. `done_o` and `odd_trap_o` last one cycle. `start_i` is ignored while busy. `mem_req_o` and `mem_addr_o` hold steady until `mem_valid_i`. Each memory read adds one cycle plus its wait cycles to the latency.
- R9: After reset `busy_o`, `done_o`, `odd_trap_o`, `mem_req_o` and `rf_we_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving `spec_i` (taken when idle) |
| spec_i | input | 6 | Operand specifier: mode[5:3], register[2:0] |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| odd_trap_o | output | 1 | One-cycle odd-address trap pulse |
| is_reg_o | output | 1 | Operand is the register named by `reg_sel_o` |
| reg_sel_o | output | 3 | Register number of the specifier |
| addr_o | output | 16 | Final operand address, or the offending address on a trap |
| rf_raddr_o | output | 3 | Register file read index |
| rf_rdata_i | input | 16 | Register file read data, combinational |
| rf_we_o | output | 1 | Register write-back strobe |
| rf_waddr_o | output | 3 | Register write-back index |
| rf_wdata_o | output | 16 | Register write-back value |
| mem_req_o | output | 1 | Memory word read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_valid_i | input | 1 | Read data valid, ends the request |
| mem_rdata_i | input | 16 | Read data |

## Verification
The bench probes the step-size boundary. It runs byte auto-increment and auto-decrement on a low register, on register 6 and on register 7, and byte deferred modes. A design that applies the byte step everywhere would corrupt the stack pointer, the PC or the pointer walk. PC-relative and immediate forms check that the extension fetch advances register 7 before the base is read. Getting that order wrong shifts the relative address by two. Odd addresses are placed at each point where the check applies: the first-cycle address, the pointer address, the indexed sum and the fetched pointer. A byte case with an odd final address checks that a design trapping on every odd address is caught. A register still modified after an early trap shows up as well. A stalled memory run with a stray start in the middle checks that the request and address hold and that no second operation is started.

// File: rtl/oea_pkg.sv
package oea_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_EXT,
    ST_PTR,
    ST_FIN,
    ST_TRAP
  } oea_state_e;

  typedef enum logic [2:0] {
    M_REG,
    M_REG_IND,
    M_POST_INC,
    M_POST_INC_IND,
    M_PRE_DEC,
    M_PRE_DEC_IND,
    M_INDEX,
    M_INDEX_IND
  } oea_mode_e;

  localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/oea_spec_dec.sv
module oea_spec_dec
  import oea_pkg::*;
#(
  parameter int unsigned RW = 3,
  localparam int unsigned SPEC_W = MODE_W + RW
) (
  input  logic [SPEC_W-1:0] spec_i,
  output logic [RW-1:0]     rnum_o,
  output logic              f_reg_o,
  output logic              f_inc_o,
  output logic              f_dec_o,
  output logic              f_idx_o,
  output logic              f_ptr_o
);

  oea_mode_e mode;

  assign mode   = oea_mode_e'(spec_i[SPEC_W-1 -: MODE_W]);
  assign rnum_o = spec_i[RW-1:0];

  always_comb begin
    f_reg_o = 1'b0;
    f_inc_o = 1'b0;
    f_dec_o = 1'b0;
    f_idx_o = 1'b0;
    f_ptr_o = 1'b0;
    unique case (mode)
      M_REG:          f_reg_o = 1'b1;
      M_REG_IND:      ;
      M_POST_INC:     f_inc_o = 1'b1;
      M_POST_INC_IND: begin f_inc_o = 1'b1; f_ptr_o = 1'b1; end
      M_PRE_DEC:      f_dec_o = 1'b1;
      M_PRE_DEC_IND:  begin f_dec_o = 1'b1; f_ptr_o = 1'b1; end
      M_INDEX:        f_idx_o = 1'b1;
      M_INDEX_IND:    begin f_idx_o = 1'b1; f_ptr_o = 1'b1; end
      default:        ;
    endcase
  end

endmodule

// File: rtl/oea_step.sv
module oea_step #(
  parameter int unsigned DW = 16,
  parameter int unsigned RW = 3,
  localparam int unsigned WSTEP = DW / 8,
  localparam logic [RW-1:0] SP_IDX = {{(RW-1){1'b1}}, 1'b0}
) (
  input  logic [DW-1:0] base_i,
  input  logic [RW-1:0] rnum_i,
  input  logic          byte_i,
  input  logic          f_ptr_i,
  input  logic          f_idx_i,
  output logic [DW-1:0] inc_o,
  output logic [DW-1:0] dec_o
);

  logic          narrow;
  logic [DW-1:0] step;

  // byte stride only for direct inc/dec on general registers below the stack pointer
  assign narrow = byte_i & ~f_ptr_i & ~f_idx_i & (rnum_i < SP_IDX);
  assign step   = narrow ? DW'(1) : DW'(WSTEP);
  assign inc_o  = base_i + step;
  assign dec_o  = base_i - step;

endmodule

// File: rtl/oea_align.sv
module oea_align #(
  parameter int unsigned AW = 1
) (
  input  logic [AW-1:0] addr_lsb_i,
  input  logic          need_word_i,
  output logic          odd_o
);

  assign odd_o = need_word_i & (|addr_lsb_i);

endmodule

// File: rtl/oea_seq.sv
module oea_seq
  import oea_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned RW = 3,
  localparam int unsigned SPEC_W = MODE_W + RW,
  localparam int unsigned AW = $clog2(DW / 8),
  localparam logic [RW-1:0] PC_IDX = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SPEC_W-1:0] spec_i,
  input  logic              byte_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              odd_trap_o,
  output logic              is_reg_o,
  output logic [RW-1:0]     reg_sel_o,
  output logic [DW-1:0]     addr_o,
  output logic [RW-1:0]     rf_raddr_o,
  input  logic [DW-1:0]     rf_rdata_i,
  output logic              rf_we_o,
  output logic [RW-1:0]     rf_waddr_o,
  output logic [DW-1:0]     rf_wdata_o,
  output logic              mem_req_o,
  output logic [DW-1:0]     mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DW-1:0]     mem_rdata_i
);

  oea_state_e        st_q, st_d;
  logic [SPEC_W-1:0] spec_q;
  logic              byte_q;
  logic [DW-1:0]     addr_q, addr_d;
  logic              isreg_q, isreg_d;

  logic [RW-1:0] rnum;
  logic          f_reg, f_inc, f_dec, f_idx, f_ptr;
  logic [DW-1:0] inc_v, dec_v;
  logic [DW-1:0] eval_addr, mem_cand;
  logic          eval_need_word, mem_need_word;
  logic          odd_eval, odd_mem;

  oea_spec_dec #(.RW(RW)) u_dec (
    .spec_i (spec_q),
    .rnum_o (rnum),
    .f_reg_o(f_reg),
    .f_inc_o(f_inc),
    .f_dec_o(f_dec),
    .f_idx_o(f_idx),
    .f_ptr_o(f_ptr)
  );

  oea_step #(.DW(DW), .RW(RW)) u_step (
    .base_i (rf_rdata_i),
    .rnum_i (rnum),
    .byte_i (byte_q),
    .f_ptr_i(f_ptr),
    .f_idx_i(f_idx),
    .inc_o  (inc_v),
    .dec_o  (dec_v)
  );

  // first-cycle address: pre-decrement result, else register (or PC for index modes)
  assign eval_addr      = f_dec ? dec_v : rf_rdata_i;
  assign eval_need_word = f_ptr | f_idx | ~byte_q;

  // memory-return address: indexed sum in ST_EXT, fetched pointer in ST_PTR
  assign mem_cand      = (st_q == ST_EXT) ? (mem_rdata_i + rf_rdata_i) : mem_rdata_i;
  assign mem_need_word = ((st_q == ST_EXT) & f_ptr) | ~byte_q;

  oea_align #(.AW(AW)) u_align_eval (
    .addr_lsb_i (eval_addr[AW-1:0]),
    .need_word_i(eval_need_word),
    .odd_o      (odd_eval)
  );

  oea_align #(.AW(AW)) u_align_mem (
    .addr_lsb_i (mem_cand[AW-1:0]),
    .need_word_i(mem_need_word),
    .odd_o      (odd_mem)
  );

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    isreg_d    = isreg_q;
    rf_we_o    = 1'b0;
    rf_waddr_o = rnum;
    rf_wdata_o = inc_v;
    rf_raddr_o = ((st_q == ST_EVAL) && f_idx) ? PC_IDX : rnum;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_EVAL;
          isreg_d = 1'b0;
        end
      end
      ST_EVAL: begin
        if (f_reg) begin
          isreg_d = 1'b1;
          st_d    = ST_FIN;
        end else begin
          addr_d = eval_addr;
          if (odd_eval) begin
            st_d = ST_TRAP;
          end else begin
            rf_we_o    = f_inc | f_dec | f_idx;
            rf_waddr_o = f_idx ? PC_IDX : rnum;
            rf_wdata_o = f_dec ? dec_v : inc_v;
            if (f_idx)      st_d = ST_EXT;
            else if (f_ptr) st_d = ST_PTR;
            else            st_d = ST_FIN;
          end
        end
      end
      ST_EXT, ST_PTR: begin
        if (mem_valid_i) begin
          addr_d = mem_cand;
          if (odd_mem)                       st_d = ST_TRAP;
          else if ((st_q == ST_EXT) && f_ptr) st_d = ST_PTR;
          else                               st_d = ST_FIN;
        end
      end
      ST_FIN, ST_TRAP: st_d = ST_IDLE;
      default:         st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      spec_q  <= '0;
      byte_q  <= 1'b0;
      addr_q  <= '0;
      isreg_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      isreg_q <= isreg_d;
      if ((st_q == ST_IDLE) && start_i) begin
        spec_q <= spec_i;
        byte_q <= byte_i;
      end
    end
  end

  assign busy_o     = (st_q == ST_EVAL) || (st_q == ST_EXT) || (st_q == ST_PTR);
  assign done_o     = (st_q == ST_FIN);
  assign odd_trap_o = (st_q == ST_TRAP);
  assign is_reg_o   = isreg_q;
  assign reg_sel_o  = rnum;
  assign addr_o     = addr_q;
  assign mem_req_o  = (st_q == ST_EXT) || (st_q == ST_PTR);
  assign mem_addr_o = addr_q;

endmodule

// File: rtl/oea_seq_chk.sv
module oea_seq_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned RW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          odd_trap_o,
  input logic          is_reg_o,
  input logic          rf_we_o,
  input logic          mem_req_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_valid_i
);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_trap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_trap_o |=> !odd_trap_o);

  a_r7_trap_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && odd_trap_o));

  a_r7_even_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !mem_addr_o[0]);

  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r3_wb_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> busy_o);

  a_r3_wb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o);

  a_r1_reg_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_reg_o) |-> !$past(mem_req_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !rf_we_o));

endmodule

bind oea_seq oea_seq_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .odd_trap_o (odd_trap_o),
  .is_reg_o   (is_reg_o),
  .rf_we_o    (rf_we_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_valid_i(mem_valid_i)
);

// File: tb/oea_seq_tb.sv
module oea_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  spec_i = '0;
  logic        byte_i = 1'b0;
  logic        busy_o, done_o, odd_trap_o, is_reg_o;
  logic [2:0]  reg_sel_o, rf_raddr_o, rf_waddr_o;
  logic [15:0] addr_o, rf_rdata_i, rf_wdata_o, mem_addr_o, mem_rdata_i;
  logic        rf_we_o, mem_req_o, mem_valid_i;

  always #2.5 clk = ~clk;

  oea_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .spec_i(spec_i), .byte_i(byte_i),
    .busy_o(busy_o), .done_o(done_o), .odd_trap_o(odd_trap_o), .is_reg_o(is_reg_o),
    .reg_sel_o(reg_sel_o), .addr_o(addr_o), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i),
    .mem_rdata_i(mem_rdata_i)
  );

  typedef struct packed {
    logic [5:0]  spec;
    logic        bop;
    logic [15:0] rinit, pcinit, m0, m1, ra0, eaddr, rfin, pcfin;
    logic        isreg, trap;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{6'o03,1'b0,16'h1234,16'h0200,16'h0000,16'h0000,16'h0000,16'h0000,16'h1234,16'h0200,1'b1,1'b0,2'd0}, // R1
    '{6'o12,1'b0,16'h0400,16'h0200,16'h0000,16'h0000,16'h0000,16'h0400,16'h0400,16'h0200,1'b0,1'b0,2'd0}, // R2
    '{6'o21,1'b0,16'h0500,16'h0200,16'h0000,16'h0000,16'h0000,16'h0500,16'h0502,16'h0200,1'b0,1'b0,2'd0}, // R3
    '{6'o21,1'b1,16'h0501,16'h0200,16'h0000,16'h0000,16'h0000,16'h0501,16'h0502,16'h0200,1'b0,1'b0,2'd0}, // R4 byte step 1
    '{6'o26,1'b1,16'h0600,16'h0200,16'h0000,16'h0000,16'h0000,16'h0600,16'h0602,16'h0200,1'b0,1'b0,2'd0}, // R4 sp step 2
    '{6'o34,1'b1,16'h0700,16'h0200,16'h0A01,16'h0000,16'h0700,16'h0A01,16'h0702,16'h0200,1'b0,1'b0,2'd1}, // R5
    '{6'o45,1'b0,16'h0800,16'h0200,16'h0000,16'h0000,16'h0000,16'h07FE,16'h07FE,16'h0200,1'b0,1'b0,2'd0}, // R3
    '{6'o40,1'b1,16'h0800,16'h0200,16'h0000,16'h0000,16'h0000,16'h07FF,16'h07FF,16'h0200,1'b0,1'b0,2'd0}, // R4
    '{6'o53,1'b0,16'h0900,16'h0200,16'h0B00,16'h0000,16'h08FE,16'h0B00,16'h08FE,16'h0200,1'b0,1'b0,2'd1}, // R5
    '{6'o62,1'b0,16'h1000,16'h0200,16'h0020,16'h0000,16'h0200,16'h1020,16'h1000,16'h0202,1'b0,1'b0,2'd1}, // R6
    '{6'o72,1'b0,16'h1000,16'h0200,16'h0030,16'h2000,16'h0200,16'h2000,16'h1000,16'h0202,1'b0,1'b0,2'd2}, // R6
    '{6'o27,1'b0,16'h0300,16'h0300,16'h0000,16'h0000,16'h0000,16'h0300,16'h0302,16'h0302,1'b0,1'b0,2'd0}, // R3 immediate
    '{6'o37,1'b0,16'h0300,16'h0300,16'h4000,16'h0000,16'h0300,16'h4000,16'h0302,16'h0302,1'b0,1'b0,2'd1}, // R5 absolute
    '{6'o67,1'b0,16'h0300,16'h0300,16'h0010,16'h0000,16'h0300,16'h0312,16'h0302,16'h0302,1'b0,1'b0,2'd1}, // R6 relative
    '{6'o77,1'b0,16'h0300,16'h0300,16'h0010,16'h5000,16'h0300,16'h5000,16'h0302,16'h0302,1'b0,1'b0,2'd2}, // R6
    '{6'o12,1'b0,16'h0401,16'h0200,16'h0000,16'h0000,16'h0000,16'h0401,16'h0401,16'h0200,1'b0,1'b1,2'd0}, // R7
    '{6'o21,1'b0,16'h0501,16'h0200,16'h0000,16'h0000,16'h0000,16'h0501,16'h0501,16'h0200,1'b0,1'b1,2'd0}, // R7 no wb
    '{6'o34,1'b1,16'h0701,16'h0200,16'h0000,16'h0000,16'h0000,16'h0701,16'h0701,16'h0200,1'b0,1'b1,2'd0}, // R7 ptr
    '{6'o62,1'b0,16'h1000,16'h0200,16'h0021,16'h0000,16'h0200,16'h1021,16'h1000,16'h0202,1'b0,1'b1,2'd1}, // R7 sum
    '{6'o62,1'b1,16'h1000,16'h0200,16'h0021,16'h0000,16'h0200,16'h1021,16'h1000,16'h0202,1'b0,1'b0,2'd1}, // R7 byte ok
    '{6'o72,1'b0,16'h1000,16'h0200,16'h0030,16'h2001,16'h0200,16'h2001,16'h1000,16'h0202,1'b0,1'b1,2'd2}, // R7 final
    '{6'o47,1'b1,16'h0300,16'h0300,16'h0000,16'h0000,16'h0000,16'h02FE,16'h02FE,16'h02FE,1'b0,1'b0,2'd0}  // R4 pc step 2
  };

  // register file and memory models
  logic [15:0] rf [8];
  logic [15:0] ld_val [8];
  logic        ld_go = 1'b0;
  vec_t        cur = '0;
  int          mem_lat = 0;
  int          rd_cnt, stall_cnt;
  logic [15:0] ra0_seen;

  assign rf_rdata_i  = rf[rf_raddr_o];
  assign mem_valid_i = mem_req_o && (stall_cnt >= mem_lat);
  assign mem_rdata_i = (rd_cnt == 0) ? cur.m0 : cur.m1;

  always @(posedge clk) begin
    if (ld_go) begin
      for (int r = 0; r < 8; r++) rf[r] <= ld_val[r];
      rd_cnt    <= 0;
      stall_cnt <= 0;
      ra0_seen  <= '0;
    end else begin
      if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
      if (mem_req_o) begin
        if (mem_valid_i) begin
          if (rd_cnt == 0) ra0_seen <= mem_addr_o;
          rd_cnt    <= rd_cnt + 1;
          stall_cnt <= 0;
        end else begin
          stall_cnt <= stall_cnt + 1;
        end
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input vec_t v);
    if (v.trap) return "R7";
    case (v.spec[5:3])
      3'd0:       return "R1";
      3'd1:       return "R2";
      3'd2, 3'd4: return "R3";
      3'd3, 3'd5: return "R5";
      default:    return "R6";
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input int lat, input bit mid);
    int    k;
    int    exp_k;
    string rq;
    rq = req_of(v);
    @(negedge clk);
    for (int r = 0; r < 8; r++) ld_val[r] = 16'h1000 + 16'(r * 16'h0100);
    ld_val[7] = v.pcinit;
    ld_val[v.spec[2:0]] = v.rinit;
    cur     = v;
    mem_lat = lat;
    ld_go   = 1'b1;
    @(negedge clk);
    ld_go   = 1'b0;
    start_i = 1'b1;
    spec_i  = v.spec;
    byte_i  = v.bop;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R8", "busy after start", 16'(busy_o), 16'h1);
    k = 1;
    while (!(done_o || odd_trap_o) && k < 60) begin
      start_i = (mid && k == 2) ? 1'b1 : 1'b0;
      spec_i  = mid ? 6'o00 : v.spec;
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    exp_k = 2 + int'(v.nrd) * (1 + lat);
    chk(k == exp_k, "R8", "latency", 16'(k), 16'(exp_k));
    chk(odd_trap_o === v.trap, rq, "trap", 16'(odd_trap_o), 16'(v.trap));
    chk(done_o === !v.trap, rq, "done", 16'(done_o), 16'(!v.trap));
    if (!v.trap) chk(is_reg_o === v.isreg, rq, "is_reg", 16'(is_reg_o), 16'(v.isreg));
    if (v.isreg) chk(reg_sel_o === v.spec[2:0], "R1", "reg_sel", 16'(reg_sel_o), 16'(v.spec[2:0]));
    else         chk(addr_o === v.eaddr, rq, "addr", addr_o, v.eaddr);
    chk(rd_cnt == int'(v.nrd), rq, "read count", 16'(rd_cnt), 16'(v.nrd));
    if (v.nrd != 0) chk(ra0_seen === v.ra0, rq, "first read addr", ra0_seen, v.ra0);
    chk(rf[v.spec[2:0]] === v.rfin, v.bop ? "R4" : rq, "register", rf[v.spec[2:0]], v.rfin);
    chk(rf[7] === v.pcfin, rq, "pc", rf[7], v.pcfin);
    @(negedge clk);
    chk(!done_o && !odd_trap_o, "R8", "pulse width", 16'({done_o, odd_trap_o}), 16'h0);
    if (mid) begin
      for (int c = 0; c < 3; c++) begin
        chk(!busy_o && !done_o, "R8", "start ignored while busy", 16'({busy_o, done_o}), 16'h0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    for (int r = 0; r < 8; r++) ld_val[r] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy_o && !done_o && !odd_trap_o && !mem_req_o && !rf_we_o, "R9", "reset outputs",
        16'({busy_o, done_o, odd_trap_o, mem_req_o, rf_we_o}), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !mem_req_o, "R9", "idle after reset", 16'({busy_o, mem_req_o}), 16'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 0, 1'b0);

    // R8 stalled memory with stray start, then R6 relative via PC under stall
    run_vec(VECS[14], 2, 1'b1);
    run_vec(VECS[13], 3, 1'b0);
    // R7 trap after stalled fetch
    run_vec(VECS[20], 1, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule